// File: doc/BRIEF.md
# Delayed Read Retry Tracker

This block sits on the target-side bus of a bridge and owns one queued delayed read at a time. It accepts a read request (direction and DWORD count) from the delayed transaction queue, then issues the read to the target. It re-issues the read each time the target answers with a retry, and counts every failed attempt in a 33-bit counter. That width lets a limit of 2^32 compare exactly.

When the number of failed attempts reaches the programmed limit, the request is dropped and a sticky error flag is set. Software clears the flag by writing 1 to it. The system error output follows the flag only while the enable bit is set. Once the target claims the cycle and is ready, the block copies one DWORD per clock into the read data queue for the opposite port. Data for a downstream request goes to the upstream queue, and data for an upstream request goes to the downstream queue.

The limit input is 33 bits wide. Its intended range is 1 to 2^32, and a typical setting is 2^24. A request length of 0 behaves as a length of 1.

Top module: `dly_read_retry_tracker`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `tgt_issue`, `up_wr_en`, `dn_wr_en`, `err_flag` and `serr_out` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. While a request is in progress, `req_ready` is 0 and `req_valid` has no effect. Loading a request clears the attempt counter.
- R3: `tgt_issue` is 1 for exactly the one cycle after a request is taken. It is also 1 for exactly the one cycle after a retry response that does not reach the limit.
- R4: Each `tgt_retry` seen while waiting counts one failed attempt. The attempt that makes the count equal to `cfg_retry_limit` sets `err_flag`, drops the request and returns `req_ready` to 1 on the next cycle. Fewer attempts leave `err_flag` unchanged.
- R5: `serr_out` equals `err_flag AND cfg_serr_en`.
- R6: `err_flag` stays 1 until a cycle with `err_clr` = 1 clears it. If a new error and a clear happen in the same cycle, the new error wins.
- R7: A DWORD is written only in a waiting cycle where `tgt_devsel` = 1, `tgt_trdy` = 1 and `tgt_retry` = 0. Device select without target ready writes nothing.
- R8: With `req_dir` = 0 (downstream) the data go to the upstream port: `up_wr_en` = 1 and `up_wr_data` = `tgt_data` in that same cycle. With `req_dir` = 1 (upstream) the data go to `dn_wr_en` and `dn_wr_data`. The other write enable stays 0.
- R9: A DWORD is accepted on every cycle with a valid handshake, with no inserted wait cycles. After `req_len` DWORDs, `req_ready` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Delayed read request present |
| req_ready | output | 1 | Tracker idle and able to take a request |
| req_dir | input | 1 | 0 = downstream read, 1 = upstream read |
| req_len | input | LEN_W (8) | DWORDs to read (0 behaves as 1) |
| tgt_issue | output | 1 | One-cycle pulse that starts an attempt on the target bus |
| tgt_devsel | input | 1 | Target claimed the cycle |
| tgt_trdy | input | 1 | Target has data ready |
| tgt_retry | input | 1 | Target asks for the attempt to be repeated |
| tgt_data | input | DATA_W (32) | Read DWORD from the target |
| up_wr_en | output | 1 | Write strobe into the upstream read data queue |
| up_wr_data | output | DATA_W (32) | Data into the upstream read data queue |
| dn_wr_en | output | 1 | Write strobe into the downstream read data queue |
| dn_wr_data | output | DATA_W (32) | Data into the downstream read data queue |
| cfg_retry_limit | input | CNT_W (33) | Failed attempts allowed before error |
| cfg_serr_en | input | 1 | System error output enable |
| err_clr | input | 1 | Write-1-to-clear for the error flag |
| err_flag | output | 1 | Sticky retry-limit error |
| serr_out | output | 1 | System error output |

## Verification
A wrong attempt count shows up as the error flag rising one retry early or late. A count left over from the previous request shows up the same way, as an error too early on the next request. The bench sees this on the cycle after the deciding retry, because `req_ready` rises or `tgt_issue` pulses on that cycle. A wrong direction bit or a wrong state shows up within the same cycle as a data beat: the strobe goes to the wrong queue, a stall cycle writes data, or a beat is lost. A wrong beat count leaves `req_ready` low, or raises it early, on the cycle after the last beat.

// File: rtl/dly_read_retry_pkg.sv
// Package: shared types for the delayed read retry tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package dly_read_retry_pkg;

    // Tracker control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no request held
        ST_ARM  = 2'd1,   // issue pulse cycle
        ST_WAIT = 2'd2    // awaiting target response / data beats
    } trk_state_e;

    // Direction of the original request
    typedef enum logic {
        DIR_DOWN = 1'b0,  // data returns toward the upstream queue
        DIR_UP   = 1'b1   // data returns toward the downstream queue
    } req_dir_e;

endpackage

// File: rtl/retry_attempt_counter.sv
// Module: retry_attempt_counter
// Counts failed attempts of one delayed read. It reports when the next
// failed attempt would make the count equal to or above the limit.
// Assumes: clr and inc are never both high; the limit is stable during a request.
module retry_attempt_counter #(
    parameter int CNT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             at_limit_next
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] count_plus;

    // Compare count+1 in a wider word so the largest limit never wraps.
    always_comb begin
        count_plus    = {1'b0, count} + EXT_W'(1);
        at_limit_next = count_plus >= {1'b0, limit};
    end

    // Attempt register: cleared on reset or load, bumped per failed attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count_plus[CNT_W-1:0];
    end

    // R4: the counter never wraps
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (count != {CNT_W{1'b1}}));

    // R2: a load leaves the counter at zero
    p_clear_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/read_data_steer.sv
// Module: read_data_steer
// Sends each accepted DWORD to the read data queue that faces the port
// opposite to the one that made the request. No storage.
// Assumes: beat is high only for a valid target data handshake.
module read_data_steer #(
    parameter int DATA_W = 32
) (
    input  logic              beat,
    input  logic              dir,
    input  logic [DATA_W-1:0] data,
    output logic              up_wr_en,
    output logic [DATA_W-1:0] up_wr_data,
    output logic              dn_wr_en,
    output logic [DATA_W-1:0] dn_wr_data
);
    import dly_read_retry_pkg::*;

    // Route the strobe by request direction; data fans out to both queues.
    always_comb begin
        up_wr_en   = beat && (dir == DIR_DOWN);
        dn_wr_en   = beat && (dir == DIR_UP);
        up_wr_data = data;
        dn_wr_data = data;
    end

    // R8: never both queues in one cycle
    always_comb begin
        a_one_queue_r8: assert (!(up_wr_en && dn_wr_en));
    end
endmodule

// File: rtl/dly_read_retry_tracker.sv
// Module: dly_read_retry_tracker (top)
// Holds one delayed read, re-issues it on retry, escalates to a sticky
// error at the attempt limit, and steers returned DWORDs one per clock.
// Assumes: the configuration is stable while a request is held; req_len 0 acts as 1.
module dly_read_retry_tracker #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_dir,
    input  logic [LEN_W-1:0]  req_len,
    output logic              tgt_issue,
    input  logic              tgt_devsel,
    input  logic              tgt_trdy,
    input  logic              tgt_retry,
    input  logic [DATA_W-1:0] tgt_data,
    output logic              up_wr_en,
    output logic [DATA_W-1:0] up_wr_data,
    output logic              dn_wr_en,
    output logic [DATA_W-1:0] dn_wr_data,
    input  logic [CNT_W-1:0]  cfg_retry_limit,
    input  logic              cfg_serr_en,
    input  logic              err_clr,
    output logic              err_flag,
    output logic              serr_out
);
    import dly_read_retry_pkg::*;

    trk_state_e       state_q, state_d;
    logic             dir_q;
    logic [LEN_W-1:0] remain_q;
    logic             load, retry_evt, beat, last_beat, limit_hit, at_limit_next;
    logic [CNT_W-1:0] attempt_cnt;

    // Decode the events of the current cycle from state and target inputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        tgt_issue = (state_q == ST_ARM);
        load      = req_valid && req_ready;
        retry_evt = (state_q == ST_WAIT) && tgt_retry;
        beat      = (state_q == ST_WAIT) && !tgt_retry && tgt_devsel && tgt_trdy;
        last_beat = beat && (remain_q <= LEN_W'(1));
        limit_hit = retry_evt && at_limit_next;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_ARM;
            ST_ARM:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (retry_evt)      state_d = limit_hit ? ST_IDLE : ST_ARM;
                else if (last_beat) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured request direction and remaining beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            remain_q <= '0;
        end else if (load) begin
            dir_q    <= req_dir;
            remain_q <= req_len;
        end else if (beat) begin
            remain_q <= remain_q - LEN_W'(1);
        end
    end

    // Sticky error flag: set at the limit wins over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_flag <= 1'b0;
        else if (limit_hit) err_flag <= 1'b1;
        else if (err_clr)   err_flag <= 1'b0;
    end

    // Gate the system error output with its enable.
    always_comb serr_out = err_flag && cfg_serr_en;

    retry_attempt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (load),
        .inc           (retry_evt),
        .limit         (cfg_retry_limit),
        .count         (attempt_cnt),
        .at_limit_next (at_limit_next)
    );

    read_data_steer #(.DATA_W(DATA_W)) u_steer (
        .beat       (beat),
        .dir        (dir_q),
        .data       (tgt_data),
        .up_wr_en   (up_wr_en),
        .up_wr_data (up_wr_data),
        .dn_wr_en   (dn_wr_en),
        .dn_wr_data (dn_wr_data)
    );

    // R3: a non-final retry re-arms on the next cycle
    p_reissue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_retry && !req_ready && !tgt_issue && !limit_hit) |=> tgt_issue);

    // R3: the issue pulse lasts one cycle
    p_issue_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_issue |=> !tgt_issue);

    // R6: the flag holds unless cleared
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R5: no system error without its enable
    p_serr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_serr_en |-> !serr_out);

    // R7: a queue write needs both device select and target ready
    p_wr_handshake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_wr_en || dn_wr_en) |-> (tgt_devsel && tgt_trdy && !tgt_retry));

    // R4: reaching the limit frees the tracker
    p_limit_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |=> (req_ready && err_flag));
endmodule

// File: tb/test_dly_read_retry_tracker.sv
// Bench for dly_read_retry_tracker. Inputs are driven on the falling edge,
// outputs checked away from the rising edge, expected values from bench functions.
module test_dly_read_retry_tracker;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;
    localparam int CNT_W  = 33;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_dir = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              tgt_devsel = 1'b0, tgt_trdy = 1'b0, tgt_retry = 1'b0;
    logic [DATA_W-1:0] tgt_data = '0;
    logic [CNT_W-1:0]  cfg_retry_limit = 33'd4;
    logic              cfg_serr_en = 1'b0, err_clr = 1'b0;
    logic              req_ready, tgt_issue, up_wr_en, dn_wr_en, err_flag, serr_out;
    logic [DATA_W-1:0] up_wr_data, dn_wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_err = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dly_read_retry_tracker #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_dly_read_retry_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dir(req_dir), .req_len(req_len), .tgt_issue(tgt_issue),
        .tgt_devsel(tgt_devsel), .tgt_trdy(tgt_trdy), .tgt_retry(tgt_retry),
        .tgt_data(tgt_data), .up_wr_en(up_wr_en), .up_wr_data(up_wr_data),
        .dn_wr_en(dn_wr_en), .dn_wr_data(dn_wr_data),
        .cfg_retry_limit(cfg_retry_limit), .cfg_serr_en(cfg_serr_en),
        .err_clr(err_clr), .err_flag(err_flag), .serr_out(serr_out));

    function automatic bit exp_limit_hit(input int retries_so_far, input int limit);
        return retries_so_far >= limit;
    endfunction

    function automatic bit exp_serr(input bit flag, input bit en);
        return flag && en;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        model_err = 1'b0;
        chk("R6 cleared by write-1", err_flag, 0);
    endtask

    // One request: nretry retry responses, then len data beats unless the limit hits.
    task automatic run_txn(input bit dir, input int len, input int nretry,
                           input int limit, input bit en, input bit stalls, input bit poke);
        bit hit = 1'b0;
        cfg_retry_limit = CNT_W'(limit);
        cfg_serr_en = en;
        #1;
        chk("R2 ready before load", req_ready, 1);
        chk("R5 serr gate idle", serr_out, exp_serr(model_err, en));
        req_valid = 1'b1; req_dir = dir; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 issue after load", tgt_issue, 1);
        chk("R2 busy not ready", req_ready, 0);
        for (int i = 0; i < nretry; i++) begin
            @(negedge clk);
            chk("R3 issue one cycle", tgt_issue, 0);
            tgt_retry = 1'b1;
            @(negedge clk);
            tgt_retry = 1'b0;
            if (exp_limit_hit(i + 1, limit)) begin
                hit = 1'b1;
                model_err = 1'b1;
                chk("R4 err at limit", err_flag, 1);
                chk("R4 released at limit", req_ready, 1);
                chk("R5 serr follows flag", serr_out, exp_serr(1'b1, en));
                break;
            end
            chk("R3 reissue after retry", tgt_issue, 1);
            chk("R4 no err below limit", err_flag, model_err);
        end
        if (!hit) begin
            @(negedge clk);
            for (int b = 0; b < len; b++) begin
                if (stalls && ($urandom_range(0, 2) == 0)) begin
                    tgt_devsel = 1'b1; tgt_trdy = 1'b0;
                    if (poke) req_valid = 1'b1;
                    #1;
                    chk("R7 no write on stall", up_wr_en || dn_wr_en, 0);
                    @(negedge clk);
                    req_valid = 1'b0;
                end
                begin
                    logic [DATA_W-1:0] d = $urandom;
                    tgt_devsel = 1'b1; tgt_trdy = 1'b1; tgt_data = d;
                    #1;
                    chk("R8 upstream strobe", up_wr_en, dir == 1'b0);
                    chk("R8 downstream strobe", dn_wr_en, dir == 1'b1);
                    chk("R9 data passed", dir ? dn_wr_data : up_wr_data, d);
                    @(negedge clk);
                end
            end
            tgt_devsel = 1'b0; tgt_trdy = 1'b0;
            #1;
            chk("R9 ready after last beat", req_ready, 1);
            chk("R6 flag unchanged by good txn", err_flag, model_err);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ready at reset", req_ready, 1);
        chk("R1 issue low", tgt_issue, 0);
        chk("R1 no writes", up_wr_en || dn_wr_en, 0);
        chk("R1 err low", err_flag, 0);
        chk("R1 serr low", serr_out, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: handshake without a request does nothing (R7)
        tgt_devsel = 1'b1; tgt_trdy = 1'b1; #1;
        chk("R7 no write while idle", up_wr_en || dn_wr_en, 0);
        @(negedge clk); tgt_devsel = 1'b0; tgt_trdy = 1'b0;

        run_txn(1'b0, 4, 0, 4, 1'b1, 1'b1, 1'b1);   // R2 poke while busy
        run_txn(1'b1, 3, 2, 4, 1'b1, 1'b0, 1'b0);
        run_txn(1'b0, 2, 3, 4, 1'b1, 1'b0, 1'b0);   // one below limit
        run_txn(1'b1, 2, 3, 4, 1'b1, 1'b0, 1'b0);   // R2 counter cleared on load
        run_txn(1'b0, 2, 4, 4, 1'b0, 1'b0, 1'b0);   // R4 exactly at limit, serr gated
        cfg_serr_en = 1'b1; #1;
        chk("R5 serr with enable", serr_out, 1);
        @(negedge clk);
        run_txn(1'b1, 1, 0, 1, 1'b1, 1'b0, 1'b0);   // R6 flag survives a good txn
        clear_err();
        run_txn(1'b0, 1, 1, 1, 1'b1, 1'b0, 1'b0);   // limit of one

        // R6: new error beats a same-cycle clear
        cfg_retry_limit = 33'd1;
        req_valid = 1'b1; req_len = 8'd1; @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        tgt_retry = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        tgt_retry = 1'b0; err_clr = 1'b0;
        chk("R6 set wins over clear", err_flag, 1);
        clear_err();

        // Constrained random mix
        for (int t = 0; t < 60; t++) begin
            int lim = $urandom_range(1, 6);
            int nr  = $urandom_range(0, lim);
            run_txn(1'($urandom_range(0, 1)), $urandom_range(1, 6), nr, lim,
                    1'($urandom_range(0, 1)), 1'b1, 1'($urandom_range(0, 1)));
            if (model_err && ($urandom_range(0, 1) == 1)) clear_err();
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule